// File: doc/BRIEF.md
# Timer/Counter with Compare Output

This block is an up-counting timer with a single output-compare channel that drives one waveform pin. A per-cycle tick enable decides when the counter advances, so any prescaler stays outside the block. A 3-bit mode input picks how the count runs. In free-running mode the counter wraps from its maximum value back to zero. In clear-on-compare mode the counter returns to zero when it reaches the compare register, so that register sets the period.

On each compare match the channel applies a 2-bit pin action to the waveform output: no change, toggle, drive low or drive high. A force strobe applies the same action at once, without a real match. The block also keeps two sticky flags, one for overflow and one for compare match. Each flag is cleared by a write-one strobe. The bus can load the counter, the compare register and the action field at any time.

Top module: `timer_cmp_unit`

## Requirements
- R1: After a synchronous active-low reset, the count, the waveform pin, both flags, the compare register and the action field are all zero.
- R2: When the mode is anything other than 2 (free-running), each cycle with tick_en high increments the count by one, and the count wraps from 0xFF to 0x00.
- R3: The overflow flag becomes 1 on the same clock edge at which a tick takes the count from 0xFF to 0x00. It then stays 1 until a clr_ovf strobe. If a wrap and a clr_ovf strobe happen on the same edge, the wrap wins.
- R4: With mode 2 (clear-on-compare), a tick on which the count equals the compare register and the match is not suppressed loads zero into the count.
- R5: The compare flag becomes 1 on the edge of every unsuppressed match (a tick with count equal to the compare register), in either mode. It stays 1 until a clr_cmp strobe, and a match wins over a clear on the same edge.
- R6: On a match, the waveform pin follows the action field: 0 leaves it unchanged, 1 toggles it, 2 drives it to 0, 3 drives it to 1.
- R7: A write to the action field does not change the pin by itself. The new value is used from the next match or force onward.
- R8: A force_cmp strobe applies the current action to the pin on that edge. It does not set the compare flag and does not clear the count.
- R9: A counter write loads the count on that edge and takes priority over counting. The first tick after the write produces no match, even when the written value equals the compare register.
- R10: On cycles with tick_en low and no counter write, the count holds, no match occurs, and neither the pin nor the compare flag changes through a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable (prescaler output) |
| mode_sel | input | 3 | Count mode: 2 = clear-on-compare, other values = free-running |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare register write value |
| act_we | input | 1 | Action field write strobe |
| act_wdata | input | 2 | Action: 0 none, 1 toggle, 2 clear, 3 set |
| force_cmp | input | 1 | Force-compare strobe |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| clr_cmp | input | 1 | Write-one clear of the compare flag |
| cnt_o | output | 8 | Current count |
| wave_o | output | 1 | Waveform output pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle: the count holds without a tick, a counter load lands on the next edge, the count clears on a clear-on-compare match, a wrap sets the overflow flag, both flags stay set until cleared, and the pin is steady when there is neither a match nor a force. Some behaviour appears only over a sequence of cycles, and the bench scenarios cover it. That includes the full period in clear-on-compare mode, an action write taking effect at a later match, a force that leaves the compare flag and the count untouched, and the match suppressed after loading a value equal to the compare register. Random traffic is compared against a bench model built from the requirements. It mixes modes, strobes and compare values.

// File: rtl/tc_pkg.sv
// Package: shared encodings for the timer/counter with compare output.
// Assumes: 2-bit action field and 3-bit mode field as in the brief.
package tc_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } pin_act_e;

    localparam logic [2:0] MODE_CLR_ON_CMP = 3'd2;
endpackage

// File: rtl/tc_counter.sv
// Module: tc_counter
// The count register, the match detection, the match suppression that
// follows a bus load, and the wrap detection.
// Assumes: compare value is registered in the parent; clr_mode is static
// or changes only between ticks.
module tc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         clr_mode,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         match,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         blk_q;

    assign match = tick_en && !blk_q && (cnt_q == cmp_val);
    assign wrap  = tick_en && !load_we && (cnt_q == CNT_MAX);
    assign count = cnt_q;

    // Count register: load wins, else a tick clears on match or increments.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load_we)           cnt_q <= load_val;
        else if (tick_en) begin
            if (clr_mode && match)  cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // Suppression flag: armed by a load, dropped by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        blk_q <= 1'b0;
        else if (load_we)  blk_q <= 1'b1;
        else if (tick_en)  blk_q <= 1'b0;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_we) |=> $stable(cnt_q));
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (cnt_q == $past(load_val)));
    a_r9_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !tick_en) |=> !match);
    a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mode && match && !load_we) |=> (cnt_q == '0));
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_we && !clr_mode) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tc_wavegen.sv
// Module: tc_wavegen
// Holds the pin action field and drives the waveform pin on a match or
// a force strobe.
// Assumes: match and force are single-cycle qualifiers from the parent.
module tc_wavegen
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_we,
    input  logic [1:0] act_wdata,
    input  logic       match,
    input  logic       force_cmp,
    output logic       wave
);
    pin_act_e act_q;
    logic     wave_q;
    logic     wave_d;
    logic     fire;

    assign fire = match || force_cmp;
    assign wave = wave_q;

    // Action field: written by the bus, used from the next edge onward.
    always_ff @(posedge clk) begin
        if (!rst_n)       act_q <= ACT_NONE;
        else if (act_we)  act_q <= pin_act_e'(act_wdata);
    end

    // Next pin level for the current action.
    always_comb begin
        case (act_q)
            ACT_TOGGLE: wave_d = ~wave_q;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave_q;
        endcase
    end

    // Pin register: changes only when a match or force fires.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave_q <= 1'b0;
        else if (fire)  wave_q <= wave_d;
    end

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(wave_q));
    a_r6_none: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_q == ACT_NONE) |=> $stable(wave_q));
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_q == ACT_TOGGLE) |=> (wave_q != $past(wave_q)));
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_q == ACT_SET) |=> wave_q);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_q == ACT_CLEAR) |=> !wave_q);
endmodule

// File: rtl/tc_flags.sv
// Module: tc_flags
// Sticky overflow and compare flags, each with a write-one clear.
// Assumes: a set event wins over a clear on the same edge.
module tc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic match,
    input  logic clr_ovf,
    input  logic clr_cmp,
    output logic ovf_flag,
    output logic cmp_flag
);
    logic ovf_q;
    logic cmp_q;

    assign ovf_flag = ovf_q;
    assign cmp_flag = cmp_q;

    // Overflow flag: set by a wrap, cleared by a write-one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (wrap)     ovf_q <= 1'b1;
        else if (clr_ovf)  ovf_q <= 1'b0;
    end

    // Compare flag: set by a match, cleared by a write-one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= 1'b0;
        else if (match)    cmp_q <= 1'b1;
        else if (clr_cmp)  cmp_q <= 1'b0;
    end

    a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);
    a_r5_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_q);
    a_r5_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q && !clr_cmp) |=> cmp_q);
endmodule

// File: rtl/timer_cmp_unit.sv
// Module: timer_cmp_unit (top)
// Timer/counter with one output-compare channel: holds the compare
// register and connects the counter, the waveform generator and the flags.
// Assumes: tick_en comes from an external prescaler; mode 2 selects
// clear-on-compare, every other mode value runs free.
module timer_cmp_unit
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [2:0]   mode_sel,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         act_we,
    input  logic [1:0]   act_wdata,
    input  logic         force_cmp,
    input  logic         clr_ovf,
    input  logic         clr_cmp,
    output logic [W-1:0] cnt_o,
    output logic         wave_o,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    logic [W-1:0] cmp_q;
    logic         clr_mode;
    logic         match;
    logic         wrap;

    assign clr_mode = (mode_sel == MODE_CLR_ON_CMP);

    // Compare register: bus-written.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_q <= '0;
        else if (cmp_we)  cmp_q <= cmp_wdata;
    end

    tc_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .clr_mode (clr_mode),
        .load_we  (cnt_we),
        .load_val (cnt_wdata),
        .cmp_val  (cmp_q),
        .count    (cnt_o),
        .match    (match),
        .wrap     (wrap)
    );

    tc_wavegen u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_we    (act_we),
        .act_wdata (act_wdata),
        .match     (match),
        .force_cmp (force_cmp),
        .wave      (wave_o)
    );

    tc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .match    (match),
        .clr_ovf  (clr_ovf),
        .clr_cmp  (clr_cmp),
        .ovf_flag (ovf_flag),
        .cmp_flag (cmp_flag)
    );

    a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick_en && !cmp_flag) |=> !cmp_flag);
    a_r8_force_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick_en && !cnt_we) |=> $stable(cnt_o));
endmodule

// File: tb/tb_timer_cmp_unit.sv
module tb_timer_cmp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       act_we = 1'b0;
    logic [1:0] act_wdata = '0;
    logic       force_cmp = 1'b0;
    logic       clr_ovf = 1'b0;
    logic       clr_cmp = 1'b0;
    logic [7:0] cnt_o;
    logic       wave_o, ovf_flag, cmp_flag;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference state derived from the requirements.
    logic [7:0] m_cnt, m_cmp;
    logic [1:0] m_act;
    logic       m_blk, m_wave, m_ovf, m_cmpf;

    always #2.5 clk = ~clk;

    timer_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .act_we(act_we), .act_wdata(act_wdata),
        .force_cmp(force_cmp), .clr_ovf(clr_ovf), .clr_cmp(clr_cmp),
        .cnt_o(cnt_o), .wave_o(wave_o), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic apply_act(input logic [1:0] a, input logic w);
        case (a)
            2'd1: return ~w;
            2'd2: return 1'b0;
            2'd3: return 1'b1;
            default: return w;
        endcase
    endfunction

    // Advance the model by one edge using the inputs currently driven.
    task automatic model_edge();
        logic mt;
        mt = tick_en && !m_blk && (m_cnt == m_cmp);
        if (mt || force_cmp) m_wave = apply_act(m_act, m_wave);
        if (tick_en && !cnt_we && m_cnt == 8'hFF) m_ovf = 1'b1;
        else if (clr_ovf) m_ovf = 1'b0;
        if (mt) m_cmpf = 1'b1;
        else if (clr_cmp) m_cmpf = 1'b0;
        if (cnt_we) m_cnt = cnt_wdata;
        else if (tick_en) m_cnt = (mode_sel == 3'd2 && mt) ? 8'h00 : m_cnt + 8'h01;
        if (cnt_we) m_blk = 1'b1;
        else if (tick_en) m_blk = 1'b0;
        if (act_we) m_act = act_wdata;
        if (cmp_we) m_cmp = cmp_wdata;
    endtask

    // Drive inputs at negedge, clock once, compare away from the edge.
    task automatic step(input logic t, input logic cw, input logic [7:0] cd,
                        input logic pw, input logic [7:0] pd,
                        input logic aw, input logic [1:0] ad,
                        input logic f, input logic co, input logic cc);
        tick_en = t; cnt_we = cw; cnt_wdata = cd; cmp_we = pw; cmp_wdata = pd;
        act_we = aw; act_wdata = ad; force_cmp = f; clr_ovf = co; clr_cmp = cc;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("R2 R4 R9 R10 count", cnt_o, m_cnt);
        chk("R3 overflow flag", ovf_flag, m_ovf);
        chk("R5 compare flag", cmp_flag, m_cmpf);
        chk("R6 R7 R8 waveform", wave_o, m_wave);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,0,0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1,0,0,0,0,0,0,0,0,0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        m_cnt = 0; m_cmp = 0; m_act = 0; m_blk = 0; m_wave = 0; m_ovf = 0; m_cmpf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count after reset", cnt_o, 0);
        chk("R1 wave after reset", wave_o, 0);
        chk("R1 ovf after reset", ovf_flag, 0);
        chk("R1 cmp flag after reset", cmp_flag, 0);

        // R2/R3: wrap in free-running mode, set flag, then clear it
        mode_sel = 3'd0;
        step(0,1,8'hFE,1,8'h40,0,0,0,0,0);
        ticks(1);
        chk("R2 count FF", cnt_o, 8'hFF);
        ticks(1);
        chk("R2 wrap to 00", cnt_o, 0);
        chk("R3 ovf set at wrap", ovf_flag, 1);
        idle(2);
        chk("R3 ovf sticky", ovf_flag, 1);
        step(0,0,0,0,0,0,0,0,1,0);
        chk("R3 ovf cleared", ovf_flag, 0);

        // R10: no tick means hold
        idle(3);
        chk("R10 count holds", cnt_o, 0);

        // R4/R5/R6: clear-on-compare with cmp=3, toggle action
        mode_sel = 3'd2;
        step(0,0,0,1,8'd3,1,2'd1,0,0,0);
        chk("R7 act write alone keeps pin", wave_o, 0);
        ticks(3);
        chk("R4 count reaches 3", cnt_o, 3);
        ticks(1);
        chk("R4 cleared at match", cnt_o, 0);
        chk("R5 cmp flag set", cmp_flag, 1);
        chk("R6 toggle on match", wave_o, 1);
        step(0,0,0,0,0,0,0,0,0,1);
        chk("R5 cmp flag cleared", cmp_flag, 0);

        // R7: change action to clear, pin unchanged until match
        step(0,0,0,0,0,1,2'd2,0,0,0);
        chk("R7 pin unchanged after write", wave_o, 1);
        ticks(4);
        chk("R7 new action at match", wave_o, 0);

        // R8: force with set action
        step(0,0,0,0,0,1,2'd3,0,0,1);
        step(0,1,8'd2,0,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,1,0,0);
        chk("R8 force sets pin", wave_o, 1);
        chk("R8 force leaves cmp flag", cmp_flag, 0);
        chk("R8 force leaves count", cnt_o, 2);

        // R9: load a value equal to compare, no match on next tick
        step(0,1,8'd3,0,0,1,2'd1,0,0,0);
        ticks(1);
        chk("R9 suppressed match count", cnt_o, 4);
        chk("R9 suppressed match flag", cmp_flag, 0);
        chk("R9 suppressed match pin", wave_o, 1);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) mode_sel = 3'($urandom_range(0, 7));
            else if (r < 6) mode_sel = 3'd2;
            step(($urandom_range(0,3) != 0),
                 ($urandom_range(0,40) == 0), 8'($urandom),
                 ($urandom_range(0,60) == 0), 8'($urandom_range(0,20)),
                 ($urandom_range(0,25) == 0), 2'($urandom),
                 ($urandom_range(0,30) == 0),
                 ($urandom_range(0,20) == 0), ($urandom_range(0,20) == 0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule